// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps through the column addresses of one read or write burst inside a row that is already open. A column command strobe captures a start column and the burst settings. From the next cycle on, the block presents one column per cycle together with a flag that marks the final beat. Bursts can be 1, 2, 4 or 8 beats long, or span a whole page. The order within a burst is either a wrapping increment or an XOR-based interleave.

A burst ends in one of three ways. It runs to its length, it is cut short by a stop strobe, or a new column command replaces it on any cycle. A single-write option limits writes to one beat, while reads keep the programmed length. The controller that uses the block keeps row activation, refresh and data movement to itself, and uses the column stream to drive the array address.

Top module: `sdr_col_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: When `start_i` is sampled high on a clock edge, the next cycle shows `valid_o` high and `col_o` equal to the `start_col_i` sampled at that edge (beat 0).
- R3: In sequential order with burst length L, beat i shows the start column with its low log2(L) bits replaced by (start + i) mod L, the upper bits unchanged.
- R4: In interleave order (`interleave_i`=1), beat i shows the start column XOR i.
- R5: `blen_code_i` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page; the reserved codes 4, 5 and 6 give 1 beat.
- R6: `last_o` is high only on the final beat of a finite burst, and `valid_o` is low in the following cycle unless a new start arrives.
- R7: A full-page sequential burst shows (start + i) mod 256, wraps from column 255 to 0, never raises `last_o`, and continues until stopped or restarted.
- R8: Code 7 combined with interleave order gives an 8-beat interleaved burst.
- R9: `stop_i` sampled high without `start_i` makes `valid_o` low in the next cycle.
- R10: `start_i` on any cycle of a running burst restarts from beat 0 at the new start column in the next cycle; when `start_i` and `stop_i` are high together, the restart wins.
- R11: With `single_write_i` high, a write start (`is_write_i`=1) gives exactly one beat whatever the code, while a read start keeps the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe: load and begin a burst |
| is_write_i | input | 1 | The command sampled with `start_i` is a write |
| start_col_i | input | 8 | Start column, sampled with `start_i` |
| blen_code_i | input | 3 | Burst length code (see R5) |
| interleave_i | input | 1 | 1 selects interleave order, 0 selects sequential |
| single_write_i | input | 1 | Writes are one beat long |
| stop_i | input | 1 | Burst stop strobe |
| valid_o | output | 1 | A burst beat is on `col_o` |
| col_o | output | 8 | Current column address |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The assertions assume that the column, code, order and single-write inputs matter only in a cycle that has `start_i` high. They also assume that `stop_i` in an idle cycle does nothing visible. Under those assumptions, every output can be traced to the most recent start. The stimulus changes inputs only on the falling clock edge. It uses the five defined length codes and one reserved code, and it issues stops and restarts at chosen beat counts, so every expected column follows from the start column and the beat index alone.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;
  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_e;
endpackage

// File: rtl/sdr_col_len_dec.sv
module sdr_col_len_dec #(
  parameter int unsigned COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             ilv_i,
  input  logic             one_beat_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  import sdr_col_pkg::*;

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    if (!one_beat_i) begin
      case (code_i)
        BLEN_2:    mask_o = COL_W'(1);
        BLEN_4:    mask_o = COL_W'(3);
        BLEN_8:    mask_o = COL_W'(7);
        BLEN_PAGE: begin
          // page length is sequential-only; interleave falls back to 8
          mask_o = ilv_i ? COL_W'(7) : '1;
          full_o = !ilv_i;
        end
        default:   mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sdr_col_beat_ctr.sv
module sdr_col_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;

  assign last_o   = active_q && !full_q && (cnt_q == mask_q);
  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      mask_q   <= mask_i;
      full_q   <= full_i;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        cnt_q    <= cnt_q + 1'b1; // page mode wraps naturally
    end
  end

  // R5: a finite burst never counts past its length
  p_cnt_in_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !full_q |-> (cnt_q & ~mask_q) == '0);

  // R7: page mode rolls over and keeps going
  p_page_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && full_q && !load_i && !stop_i && (cnt_q == '1)
    |=> active_q && (cnt_q == '0));
endmodule

// File: rtl/sdr_col_map.sv
module sdr_col_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign sum     = base_i + cnt_i;
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv_col = base_i ^ (cnt_i & mask_i);
  assign col_o   = ilv_i ? ilv_col : seq_col;
endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_code_i,
  input  logic             interleave_i,
  input  logic             single_write_i,
  input  logic             stop_i,
  output logic             valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] run_mask;
  logic [COL_W-1:0] base_q;
  logic             ilv_q;

  sdr_col_len_dec #(.COL_W(COL_W)) u_dec (
    .code_i     (blen_code_i),
    .ilv_i      (interleave_i),
    .one_beat_i (is_write_i && single_write_i),
    .mask_o     (dec_mask),
    .full_o     (dec_full)
  );

  sdr_col_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .stop_i   (stop_i),
    .mask_i   (dec_mask),
    .full_i   (dec_full),
    .active_o (valid_o),
    .cnt_o    (cnt),
    .mask_o   (run_mask),
    .last_o   (last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= start_col_i;
      ilv_q  <= interleave_i;
    end
  end

  sdr_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base_q),
    .cnt_i  (cnt),
    .mask_i (run_mask),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  p_start_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(start_col_i)));

  p_last_in_burst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_idle_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o);

  p_single_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && is_write_i && single_write_i |=> last_o);
endmodule

// File: tb/sdr_col_gen_bench.sv
module sdr_col_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] blen_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       single_write_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       valid_o;
  logic [7:0] col_o;
  logic       last_o;

  typedef struct {
    logic [7:0] col;
    logic       last;
    string      tag;
  } beat_t;

  beat_t exp_q[$];
  int    n_vec = 0;
  int    n_err = 0;
  logic  mon_en = 1'b0;

  always #10 clk_i = ~clk_i;

  sdr_col_gen u_sdr_col_gen (.*);

  function automatic int burst_len(input logic [2:0] code, input logic ilv,
                                   input logic wr, input logic sw);
    if (wr && sw) return 1;           // R11
    case (code)                       // R5
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return ilv ? 8 : 256;     // R8 / R7
      default: return 1;
    endcase
  endfunction

  // R2 R3 R4 R7: expected column of beat i
  function automatic logic [7:0] exp_col(input logic [7:0] s, input int i,
                                         input int len, input logic ilv);
    logic [7:0] m;
    logic [7:0] ii;
    m  = 8'(len - 1);
    ii = 8'(i);
    if (ilv) return s ^ (ii & m);
    return (s & ~m) | ((s + ii) & m);
  endfunction

  // Called at a falling edge; returns at the falling edge where a stop or
  // restart cuts the burst after `cut` beats, or after the natural end.
  task automatic burst(input logic [7:0] s, input logic [2:0] code,
                       input logic ilv, input logic wr, input logic sw,
                       input int cut, input logic with_stop, input string tag);
    int len;
    int n;
    beat_t b;
    len = burst_len(code, ilv, wr, sw);
    n = (cut < len) ? cut : len;
    for (int i = 0; i < n; i++) begin
      b.col  = exp_col(s, i, len, ilv);
      b.last = (len != 256) && (i == len - 1);
      b.tag  = tag;
      exp_q.push_back(b);
    end
    start_col_i = s; blen_code_i = code; interleave_i = ilv;
    is_write_i = wr; single_write_i = sw;
    start_i = 1'b1; stop_i = with_stop;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
    repeat (n - 1) @(negedge clk_i);
  endtask

  task automatic stop_now();
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  // monitor: compare each cycle a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (mon_en) begin
        n_vec++;
        if (valid_o) begin
          if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL R9/R6 unexpected beat: valid=1 col=%02h, expected valid=0", col_o);
          end else begin
            beat_t b;
            b = exp_q.pop_front();
            if (col_o !== b.col || last_o !== b.last) begin
              n_err++;
              $display("FAIL %s col=%02h last=%0b, expected col=%02h last=%0b",
                       b.tag, col_o, last_o, b.col, b.last);
            end
          end
        end else if (exp_q.size() != 0) begin
          n_err++;
          $display("FAIL %s missing beat: valid=0, expected col=%02h",
                   exp_q[0].tag, exp_q[0].col);
          void'(exp_q.pop_front());
        end else if (last_o !== 1'b0) begin
          n_err++;
          $display("FAIL R6 last=%0b while idle, expected 0", last_o);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired, expected run to finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #30;
    n_vec++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1 valid=%0b last=%0b, expected 0 0", valid_o, last_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle(2);
    burst(8'h0E, 3'd2, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R3 seq len4");
    idle(1);
    burst(8'h35, 3'd3, 1'b1, 1'b0, 1'b0, 99, 1'b0, "R4 ilv len8");
    burst(8'h81, 3'd1, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R5 len2");
    burst(8'h44, 3'd0, 1'b0, 1'b1, 1'b0, 99, 1'b0, "R5 len1");
    burst(8'h27, 3'd5, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R5 reserved code");
    idle(2);
    burst(8'h5D, 3'd3, 1'b0, 1'b0, 1'b0, 99, 1'b0, "R6 seq len8");
    idle(1);
    burst(8'hFC, 3'd7, 1'b0, 1'b0, 1'b0, 260, 1'b0, "R7 page wrap");
    stop_now();
    idle(1);
    burst(8'h9B, 3'd7, 1'b1, 1'b0, 1'b0, 99, 1'b0, "R8 ilv page code");
    idle(1);
    burst(8'h10, 3'd3, 1'b0, 1'b0, 1'b0, 3, 1'b0, "R9 stop mid");
    stop_now();
    idle(2);
    stop_now();                       // R9 stop while idle: no beat
    burst(8'hA6, 3'd3, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R10 cut by restart");
    burst(8'h3B, 3'd2, 1'b0, 1'b1, 1'b0, 1, 1'b0, "R10 restart");
    burst(8'hC2, 3'd1, 1'b0, 1'b0, 1'b0, 99, 1'b1, "R10 start beats stop");
    idle(1);
    burst(8'h6F, 3'd2, 1'b0, 1'b1, 1'b1, 99, 1'b0, "R11 single write");
    idle(1);
    burst(8'h6F, 3'd2, 1'b0, 1'b0, 1'b1, 99, 1'b0, "R11 read keeps len");
    burst(8'h73, 3'd1, 1'b1, 1'b1, 1'b0, 99, 1'b0, "R11 write no single");
    idle(4);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL R6 %0d beats never seen, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule